// File: doc/BRIEF.md
# Streaming RGB to Luminance Converter

The block turns a stream of packed 24-bit colour pixels into 8-bit luminance samples. It forms a weighted sum of the three channels with fixed-point constants close to 0.3, 0.59 and 0.11, then rounds to the nearest integer. It accepts one pixel per clock on a valid/ready input and delivers results on a valid/ready output through a two-stage registered pipeline.

A frame counter tracks accepted pixels. The output that carries the final pixel of a frame (`ROWS` x `COLS` pixels, 64 x 64 by default) is tagged with an end-of-frame flag. Back-pressure is handled by stalling the whole pipeline: the input is ready exactly when the output is ready. A held output therefore stays frozen, and no pixel is dropped or duplicated.

Top module: `luma_stream`

## Requirements
- R1: Input word layout: red is `in_rgb[7:0]`, green is `in_rgb[15:8]` and blue is `in_rgb[23:16]`. The weights are red 76, green 151 and blue 28.
- R2: Let S = 76·R + 151·G + 28·B. `out_luma` equals S[15:8] + S[7], clamped to 255.
- R3: Every `out_luma` is within 1 of (30·R + 59·G + 11·B + 50) / 100, computed in integer division.
- R4: `in_ready` equals `out_ready` in every cycle. A pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_luma` and `out_last` hold their values.
- R6: Each accepted pixel yields exactly one output transfer, in acceptance order. Cycles with `in_valid` low yield nothing.
- R7: `out_last` is high only on the output of the accepted pixel numbered ROWS·COLS−1 in a frame (counting from 0). Numbering then restarts at 0.
- R8: A synchronous active-high `rst` empties the pipeline (`out_valid` low after the edge) and restarts pixel numbering at 0.
- R9: If a pixel is accepted and `out_ready` is high at the next edge, its result is presented on `out_valid` after that edge. This gives two register stages of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel (mirrors out_ready) |
| in_rgb | input | 24 | Packed pixel: blue, green, red from MSB to LSB |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the sample |
| out_luma | output | 8 | Luminance sample |
| out_last | output | 1 | Sample belongs to the last pixel of a frame |

## Verification
The hardest situation to reach is an end-of-frame pixel that is held in the pipeline by a stall while a new frame is already being counted, combined with input gaps. The bench reaches it with small frame dimensions, so frame boundaries come every few pixels. It toggles `out_ready` pseudo-randomly and sends pixels with random idle cycles, so stalls land on last pixels and next to them. A scoreboard queue carries the frame position of each accepted pixel to the point where its result leaves the block.

// File: rtl/luma_pkg.sv
package luma_pkg;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned NCH    = 3;
  localparam int unsigned PIX_W  = CH_W * NCH;
  localparam int unsigned PROD_W = 2 * CH_W;
  localparam int unsigned SUM_W  = PROD_W + 2;

  typedef logic [NCH-1:0][CH_W-1:0]   pix_t;
  typedef logic [NCH-1:0][PROD_W-1:0] prod_t;

  // index 0 = red, 1 = green, 2 = blue
  localparam pix_t WEIGHTS = {8'd28, 8'd151, 8'd76};
endpackage

// File: rtl/luma_frame_cnt.sv
module luma_frame_cnt #(
  parameter int unsigned TOTAL = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic at_last
);
  localparam int unsigned CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] count;

  assign at_last = (count == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      count <= at_last ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/luma_weigh.sv
module luma_weigh
  import luma_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  in_valid,
  input  logic  in_last,
  input  pix_t  in_pix,
  output logic  s_valid,
  output logic  s_last,
  output prod_t s_prod
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (adv) begin
        s_prod[ch] <= PROD_W'(in_pix[ch]) * PROD_W'(WEIGHTS[ch]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_last  <= 1'b0;
    end else if (adv) begin
      s_valid <= in_valid;
      s_last  <= in_valid & in_last;
    end
  end
endmodule

// File: rtl/luma_round.sv
module luma_round
  import luma_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            s_valid,
  input  logic            s_last,
  input  prod_t           s_prod,
  output logic            o_valid,
  output logic            o_last,
  output logic [CH_W-1:0] o_luma
);
  localparam int unsigned HI_W = SUM_W - CH_W;
  localparam logic [HI_W-1:0] MAX_OUT = HI_W'((1 << CH_W) - 1);

  logic [SUM_W-1:0] sum;
  logic [HI_W-1:0]  hi;
  logic [CH_W-1:0]  luma_next;

  always_comb begin
    sum = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      sum = sum + SUM_W'(s_prod[ch]);
    end
    hi = sum[SUM_W-1:CH_W] + HI_W'(sum[CH_W-1]);
    luma_next = (hi > MAX_OUT) ? CH_W'(MAX_OUT) : hi[CH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_luma <= luma_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_last  <= 1'b0;
    end else if (adv) begin
      o_valid <= s_valid;
      o_last  <= s_last;
    end
  end
endmodule

// File: rtl/luma_stream.sv
module luma_stream
  import luma_pkg::*;
#(
  parameter int unsigned ROWS = 64,
  parameter int unsigned COLS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_rgb,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CH_W-1:0]  out_luma,
  output logic             out_last
);
  localparam int unsigned TOTAL = ROWS * COLS;

  logic  adv;
  logic  accept;
  logic  at_last;
  logic  s_valid;
  logic  s_last;
  prod_t s_prod;

  // whole pipeline moves only when the consumer takes data
  assign adv      = out_ready;
  assign in_ready = out_ready;
  assign accept   = in_valid & out_ready;

  luma_frame_cnt #(.TOTAL(TOTAL)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .step    (accept),
    .at_last (at_last)
  );

  luma_weigh u_weigh (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_valid (in_valid),
    .in_last  (at_last),
    .in_pix   (pix_t'(in_rgb)),
    .s_valid  (s_valid),
    .s_last   (s_last),
    .s_prod   (s_prod)
  );

  luma_round u_round (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .s_valid (s_valid),
    .s_last  (s_last),
    .s_prod  (s_prod),
    .o_valid (out_valid),
    .o_last  (out_last),
    .o_luma  (out_luma)
  );
endmodule

// File: rtl/luma_stream_chk.sv
module luma_stream_chk #(
  parameter int unsigned ROWS = 64,
  parameter int unsigned COLS = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [23:0] in_rgb,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_luma,
  input logic        out_last
);
  localparam int unsigned TOTAL = ROWS * COLS;
  localparam int unsigned OC_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic [OC_W-1:0] out_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_idx <= '0;
    end else if (out_valid && out_ready) begin
      out_idx <= (out_idx == OC_W'(TOTAL - 1)) ? '0 : out_idx + 1'b1;
    end
  end

  // R4
  ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready == out_ready);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_luma) && $stable(out_last)));

  // R7
  last_pos_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last == (out_idx == OC_W'(TOTAL - 1))));

  // R8
  reset_flush_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready && !rst) && out_ready) |=> out_valid);
endmodule

bind luma_stream luma_stream_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/luma_stream_tb.sv
module luma_stream_tb;
  localparam int ROWS  = 3;
  localparam int COLS  = 5;
  localparam int TOTAL = ROWS * COLS;

  typedef struct {
    logic [23:0] rgb;
    logic [7:0]  luma;
    logic        last;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_rgb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_luma;
  logic        out_last;

  int    checks = 0;
  int    fails  = 0;
  int    idx    = 0;
  bit    stall_mode = 1'b0;
  bit    done = 1'b0;
  item_t sb[$];

  bit        prev_stall = 1'b0;
  logic [7:0] prev_luma;
  logic       prev_last;

  always #2 clk = ~clk;

  luma_stream #(.ROWS(ROWS), .COLS(COLS)) u_dut (.*);

  function automatic logic [7:0] ref_luma(logic [23:0] p);
    int s;
    int h;
    s = 76 * p[7:0] + 151 * p[15:8] + 28 * p[23:16];
    h = (s >> 8) + ((s >> 7) & 1);
    return (h > 255) ? 8'd255 : 8'(h);
  endfunction

  function automatic int real_luma(logic [23:0] p);
    return (30 * p[7:0] + 59 * p[15:8] + 11 * p[23:16] + 50) / 100;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // consumer readiness, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      check(in_ready == out_ready, "R4 in_ready", int'(in_ready), int'(out_ready));
      if (prev_stall) begin
        check(out_valid && out_luma == prev_luma && out_last == prev_last,
              "R5 held output", int'(out_luma), int'(prev_luma));
      end
      prev_stall = out_valid && !out_ready;
      prev_luma  = out_luma;
      prev_last  = out_last;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected output", 1, 0);
        end else begin
          item_t e;
          int d;
          e = sb.pop_front();
          check(out_luma == e.luma, "R1 R2 luma", int'(out_luma), int'(e.luma));
          check(out_last == e.last, "R7 last flag", int'(out_last), int'(e.last));
          d = int'(out_luma) - real_luma(e.rgb);
          check(d >= -1 && d <= 1, "R3 error bound", int'(out_luma), real_luma(e.rgb));
        end
      end
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic send(logic [23:0] px);
    bit acc;
    in_valid = 1'b1;
    in_rgb   = px;
    do begin
      @(negedge clk);
      acc = in_ready;
      if (acc) begin
        item_t it;
        it.rgb  = px;
        it.luma = ref_luma(px);
        it.last = (idx == TOTAL - 1);
        sb.push_back(it);
        idx = (idx == TOTAL - 1) ? 0 : idx + 1;
      end
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    stall_mode = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    while (sb.size() != 0 || out_valid) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R8: empty after reset
    check(out_valid == 1'b0, "R8 reset state", int'(out_valid), 0);
    @(posedge clk);
    #1;

    // R1 R2 corner pixels, no stalls
    send(24'h000000);
    send(24'hFFFFFF);
    send(24'h0000FF);
    send(24'h00FF00);
    send(24'hFF0000);
    send(24'h808080);
    drain();

    // R9 latency from acceptance to presentation
    send(24'h123456);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R9 two edges after accept", int'(out_valid), 1);
    drain();

    // R8 reset mid-frame restarts numbering
    for (int i = 0; i < 4; i++) send(24'h10 * i + 24'h030201);
    drain();
    @(posedge clk);
    #1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    idx = 0;
    for (int i = 0; i < TOTAL; i++) send({$urandom} & 24'hFFFFFF);
    drain();

    // R5 R6 R7 random pixels, gaps and back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 600; i++) begin
      send({$urandom} & 24'hFFFFFF);
      if (($urandom % 4) == 0) begin
        @(posedge clk);
        #1;
      end
    end
    drain();
    check(sb.size() == 0, "R6 all outputs seen", sb.size(), 0);
    finish_run();
  end
endmodule